// File: doc/BRIEF.md
# Serial Tree-Node Address Matcher

This block sits beside one switchable buffer on the return branch of a clock distribution tree. A shared two-wire link, made of a serial clock line and a serial data line, reaches every such node. A controller first sends a line reset, then streams a branch address with the most significant tree level first. Each bit is 1 for the up or right branch and 0 for the down or left branch. The node accepts exactly as many bits as its depth in the tree. It then stops shifting, so any further bits on the shared line, which are meant for deeper nodes or for a data word, cannot change what it holds.

Both wires are sampled in the system clock domain through synchronisers. A rising edge on the serial clock line captures one data bit. A change of the data line while the serial clock line stays high is a line reset: it clears the captured bits and drops the match. Once the chain is full and the captured bits equal the node's fixed address, the match flag rises. It drives the buffer enable and holds until the next line reset.

Top module: `tree_node_matcher`

## Requirements
- R1: While `rst_n` is low, and right after it, `hit` and `buf_en` are 0.
- R2: Each rising edge of `ser_clk` captures `ser_dat` as one address bit, most significant tree level first. After exactly `NODE_LEVEL` bits equal to `NODE_ADDR` (default 3'b101), `hit` becomes 1.
- R3: With fewer than `NODE_LEVEL` bits received since the last line reset, `hit` stays 0, even when the bits received so far agree with the address.
- R4: Once `NODE_LEVEL` bits are held, later `ser_clk` edges are ignored. A match stays a match, and a mismatch cannot become a match by more bits.
- R5: A full set of bits that differs from `NODE_ADDR` in any position leaves `hit` at 0.
- R6: A change of `ser_dat` while `ser_clk` is high (a line reset) clears the received bits and sets `hit` to 0.
- R7: Once set, `hit` stays 1 until the next line reset or `rst_n`.
- R8: `buf_en` equals `hit` at all times.
- R9: A change of `ser_dat` while `ser_clk` is low is neither a bit nor a line reset.
- R10: When a line reset is seen in the cycle in which the last matching bit would raise `hit`, the reset wins: `hit` stays 0 and the chain is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock line, rising edge captures a bit |
| ser_dat | input | 1 | Serial data line; a change while ser_clk is high is a line reset |
| hit | output | 1 | Full address received and equal to the node address |
| buf_en | output | 1 | Enable for the return-path buffer at this node |

## Verification
The two functions that can meet in one cycle are forming the match from the last address bit and clearing on a line reset. In the synchronised domain, a line reset can follow the capture of the final bit by a single system cycle, which is the cycle in which `hit` would be registered. The bench provokes this by raising `ser_clk` with the final matching bit and flipping `ser_dat` on the very next system cycle. It expects `hit` never to be seen high around that point, and expects a fresh full address sent afterwards to match, which shows that the chain was empty.

// File: rtl/tnm_pkg.sv
package tnm_pkg;

    // Events decoded from the two serial lines, one system cycle wide.
    typedef struct packed {
        logic clk_rise;   // rising edge on the serial clock line
        logic line_rst;   // data changed while the serial clock line stayed high
        logic bit_val;    // data value at the moment of the clock edge
    } ser_evt_t;

    // Match register state at the top level.
    typedef struct packed {
        logic hit;
    } match_state_t;

endpackage

// File: rtl/tnm_line_watch.sv
module tnm_line_watch
    import tnm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser_clk,
    input  logic     ser_dat,
    output ser_evt_t evt
);

    // One extra stage beyond the synchroniser holds the previous value.
    localparam int PW   = SYNC_STAGES + 1;
    localparam int NOW  = PW - 2;
    localparam int PREV = PW - 1;

    typedef struct packed {
        logic [PW-1:0] sc;
        logic [PW-1:0] sd;
    } watch_t;

    watch_t watch_d, watch_q;

    always_comb begin
        watch_d    = watch_q;
        watch_d.sc = {watch_q.sc[PW-2:0], ser_clk};
        watch_d.sd = {watch_q.sd[PW-2:0], ser_dat};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_q <= '0;
        end else begin
            watch_q <= watch_d;
        end
    end

    always_comb begin
        evt          = '0;
        evt.clk_rise = watch_q.sc[NOW] & ~watch_q.sc[PREV];
        evt.line_rst = watch_q.sc[NOW] & watch_q.sc[PREV]
                     & (watch_q.sd[NOW] ^ watch_q.sd[PREV]);
        evt.bit_val  = watch_q.sd[NOW];
    end

    // R2: a single serial clock edge yields a single capture event.
    p_one_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.clk_rise |=> !evt.clk_rise);

    // R10: a capture and a line reset never share a cycle, so the order is defined.
    p_evt_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt.line_rst |-> !$past(evt.line_rst) || !evt.clk_rise);

endmodule

// File: rtl/tnm_shift_chain.sv
module tnm_shift_chain
    import tnm_pkg::*;
#(
    parameter int LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ser_evt_t         evt,
    output logic [LEVEL-1:0] addr,
    output logic             full
);

    localparam int CW = $clog2(LEVEL + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(LEVEL);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [LEVEL-1:0] sh;
    } chain_t;

    chain_t chain_d, chain_q;
    logic   chain_full;

    assign chain_full = (chain_q.cnt == CNT_FULL);

    always_comb begin
        chain_d = chain_q;
        if (evt.line_rst) begin
            chain_d.cnt = '0;
            chain_d.sh  = '0;
        end else if (evt.clk_rise && !chain_full) begin
            // The earliest bit ends in the top position after LEVEL shifts.
            chain_d.sh  = (chain_q.sh << 1) | LEVEL'(evt.bit_val);
            chain_d.cnt = chain_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign addr = chain_q.sh;
    assign full = chain_full;

    // R3: the count never passes the node depth.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q.cnt <= CNT_FULL);

    // R4: a full chain keeps its contents until a line reset.
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_full && !evt.line_rst) |=> ($stable(chain_q.sh) && full));

    // R6: a line reset empties the chain.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.line_rst |=> (chain_q.cnt == '0 && chain_q.sh == '0));

endmodule

// File: rtl/tnm_addr_cmp.sv
module tnm_addr_cmp #(
    parameter int               LEVEL     = 3,
    parameter logic [LEVEL-1:0] NODE_ADDR = 3'b101
) (
    input  logic [LEVEL-1:0] addr,
    input  logic             full,
    output logic             match
);

    logic [LEVEL-1:0] bit_eq;

    for (genvar gi = 0; gi < LEVEL; gi++) begin : g_bit
        assign bit_eq[gi] = ~(addr[gi] ^ NODE_ADDR[gi]);
    end

    assign match = full & (&bit_eq);

endmodule

// File: rtl/tree_node_matcher.sv
module tree_node_matcher
    import tnm_pkg::*;
#(
    parameter int                    NODE_LEVEL  = 3,
    parameter logic [NODE_LEVEL-1:0] NODE_ADDR   = 3'b101,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic hit,
    output logic buf_en
);

    ser_evt_t              evt;
    logic [NODE_LEVEL-1:0] chain_addr;
    logic                  chain_full;
    logic                  addr_match;
    match_state_t          state_d, state_q;

    tnm_line_watch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .evt     (evt)
    );

    tnm_shift_chain #(
        .LEVEL (NODE_LEVEL)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .addr  (chain_addr),
        .full  (chain_full)
    );

    tnm_addr_cmp #(
        .LEVEL     (NODE_LEVEL),
        .NODE_ADDR (NODE_ADDR)
    ) u_cmp (
        .addr  (chain_addr),
        .full  (chain_full),
        .match (addr_match)
    );

    always_comb begin
        state_d = state_q;
        if (evt.line_rst) begin
            state_d.hit = 1'b0;           // reset wins over a match forming now
        end else if (addr_match) begin
            state_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit    = state_q.hit;
    assign buf_en = state_q.hit;

    // R2: the flag is only up with a full chain behind it.
    p_hit_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> chain_full);

    // R5: the flag is only up when the held bits equal the node address.
    p_hit_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (chain_addr == NODE_ADDR));

    // R6: a line reset drops the flag on the next cycle.
    p_hit_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.line_rst |=> !hit);

    // R7: the flag holds while no line reset arrives.
    p_hit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !evt.line_rst) |=> hit);

endmodule

// File: tb/tb_tree_node_matcher.sv
module tb_tree_node_matcher;

    localparam int LEVEL = 3;
    localparam logic [LEVEL-1:0] ADDR = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic hit, buf_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tree_node_matcher #(
        .NODE_LEVEL (LEVEL),
        .NODE_ADDR  (ADDR)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .hit     (hit),
        .buf_en  (buf_en)
    );

    // {length[3:0], bits[7:0] sent from bit length-1 down to 0, expected hit}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {4'd3, 8'b0000_0101, 1'b1},   // R2 exact address
        {4'd3, 8'b0000_0100, 1'b0},   // R5 last bit wrong
        {4'd3, 8'b0000_0001, 1'b0},   // R5 first bit wrong
        {4'd2, 8'b0000_0010, 1'b0},   // R3 correct prefix, too short
        {4'd5, 8'b0001_0111, 1'b1},   // R4 match then extra bits
        {4'd5, 8'b0001_1101, 1'b0},   // R4 mismatch then extra bits
        {4'd4, 8'b0000_1010, 1'b1},   // R4 one extra bit
        {4'd3, 8'b0000_0111, 1'b0},   // R5 middle bit wrong
        {4'd5, 8'b0000_0101, 1'b0}    // R4 late bits equal address, first three do not
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic line_reset();
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_dat = ~ser_dat;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        check("R1 hit in reset", hit, 1'b0);
        check("R1 buf_en in reset", buf_en, 1'b0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 hit after reset", hit, 1'b0);

        for (int v = 0; v < NV; v++) begin
            line_reset();
            for (int i = int'(VEC[v][12:9]) - 1; i >= 0; i--) begin
                send_bit(VEC[v][1 + i]);
            end
            wait_cyc(4);
            check($sformatf("R2/R3/R4/R5 vector %0d hit", v), hit, VEC[v][0]);
            check($sformatf("R8 vector %0d buf_en", v), buf_en, VEC[v][0]);
        end

        // R7 and R9: hold through data changes with the clock low and extra edges.
        line_reset();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        wait_cyc(4);
        check("R2 match before hold", hit, 1'b1);
        for (int k = 0; k < 4; k++) begin
            ser_dat = ~ser_dat;
            wait_cyc(5);
        end
        check("R9 data toggles with clock low keep hit", hit, 1'b1);
        send_bit(1'b0); send_bit(1'b0);
        wait_cyc(20);
        check("R7 hit held after extra bits", hit, 1'b1);

        // R6: line reset drops the flag.
        line_reset();
        check("R6 hit after line reset", hit, 1'b0);
        check("R8 buf_en after line reset", buf_en, 1'b0);

        // R9: data toggling with clock low between bits does not reset the chain.
        send_bit(1'b1);
        ser_dat = ~ser_dat; wait_cyc(5);
        ser_dat = ~ser_dat; wait_cyc(5);
        send_bit(1'b0); send_bit(1'b1);
        wait_cyc(4);
        check("R9 chain kept across low-clock toggles", hit, 1'b1);

        // R10: line reset one system cycle after the final matching bit.
        begin
            logic seen;
            seen = 1'b0;
            line_reset();
            send_bit(1'b1); send_bit(1'b0);
            ser_dat = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b1;
            @(negedge clk);
            ser_dat = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (hit) seen = 1'b1;
            end
            ser_clk = 1'b0;
            wait_cyc(4);
            check("R10 hit never raised on coincident reset", seen, 1'b0);
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
            wait_cyc(4);
            check("R10 chain empty after coincident reset", hit, 1'b1);
        end

        // R1: synchronous reset clears a held match.
        rst_n = 1'b0;
        wait_cyc(2);
        check("R1 hit cleared by rst_n", hit, 1'b0);
        rst_n = 1'b1;
        wait_cyc(4);
        send_bit(1'b1);
        wait_cyc(4);
        check("R3 one bit after rst_n no hit", hit, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule